// File: doc/BRIEF.md
# Instruction-Quantum Round-Robin Priority Rotator

This block spreads execution fairly across the thread slots that carry no real-time demand. Each slot holds a budget counter of instructions. The issue stage reports every cycle how many instructions each slot issued, and the block subtracts that count from the slot's budget. When a slot's budget runs out, the slot drops to the bottom of a ranked list and its budget is refilled. The slots that ranked below it each move up one place. There are no rounds: budgets are refilled only when they run out, never on a timer.

The ranked list is the block's output, and it is offered in two forms. The first gives, for each position, the slot index held there. The second gives, for each slot, a priority level, where a larger level means a higher priority. Levels run from 0 to NUM_SLOTS-1. The issue stage places its real-time slots at levels NUM_SLOTS and above, so every slot ranked here sits below all real-time work. Budgets may differ from slot to slot. With unequal budgets, a slot with a small budget can run out first and pass a slot that ranked above it. This is expected behaviour.

Top module: `rriq_sched`

## Requirements
- R1: While `rst` is high at a clock edge, the list is reset so that slot p holds position p, with position 0 the highest. At the same time, each budget counter is loaded from its slot's quantum input.
- R2: The level of a slot is NUM_SLOTS-1 minus its position. The slot at position 0 has level NUM_SLOTS-1 and the slot at the last position has level 0.
- R3: In a cycle where no slot issues, the list is left unchanged at the next edge.
- R4: Each cycle, a slot's counter drops by that slot's issue count. The slot is exhausted in the cycle where its issue count is at least the remaining count. The list shows the result after the next clock edge.
- R5: An exhausted slot moves to the last position. Every slot that ranked below it moves up one position. Slots that ranked above it keep their positions.
- R6: When a slot is exhausted, its counter is reloaded with the quantum present on its input in that cycle. Issues beyond the remaining count in that cycle are discarded and do not carry over.
- R7: The quantum input is sampled only at reset and at reload. Changing it at any other time does not change the count already in progress.
- R8: When several slots are exhausted in the same cycle, the slots that were not exhausted fill the top positions in their previous relative order. The exhausted slots fill the bottom positions in reverse order of rank, so the exhausted slot that ranked highest ends last.
- R9: With unequal quanta, a lower-ranked slot that is exhausted first ends up ahead of a higher-ranked slot that is exhausted later.
- R10: A quantum of 0 is treated as 1.
- R11: The position list is always a permutation of the slot indices 0 to NUM_SLOTS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| quantum_i | input | NUM_SLOTS x QW | Instruction budget for each slot, sampled at reset and at reload |
| issue_cnt_i | input | NUM_SLOTS x IW | Number of instructions each slot issued this cycle |
| order_o | output | NUM_SLOTS x SW | Slot index held at each position; element 0 is the highest position |
| level_o | output | NUM_SLOTS x SW | Priority level of each slot; larger means higher |

## Verification
The hardest case to reach is two slots running out of budget in the same cycle. Their counters must reach zero on exactly the same edge, and by then they must no longer be adjacent in the list, so that the tail order and the upward shift are both visible. The stimulus gets there in steps. It first rotates slots until the two targets sit at non-adjacent positions with known remaining counts. It then issues to both at rates chosen so that they run out together. A reference model in the bench follows every cycle, and a long pseudo-random issue pattern with mixed quanta then covers the remaining orderings.

// File: rtl/rriq_pkg.sv
package rriq_pkg;

    localparam int DEF_SLOTS     = 4;
    localparam int DEF_QW        = 8;
    localparam int DEF_MAX_ISSUE = 2;

    // What happens to the slot sitting at one list position this cycle
    typedef enum logic {
        FATE_STAY   = 1'b0,
        FATE_ROTATE = 1'b1
    } slot_fate_e;

    function automatic slot_fate_e fate_of(input logic exhausted);
        return exhausted ? FATE_ROTATE : FATE_STAY;
    endfunction

    // Width needed to index n items (at least one bit)
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rriq_slot_ctr.sv
module rriq_slot_ctr
    import rriq_pkg::*;
#(
    parameter int QW = DEF_QW,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [QW-1:0] quantum_i,
    input  logic [IW-1:0] issue_i,
    output logic          exhaust_o
);

    logic [QW-1:0] remain_q;
    logic [QW-1:0] refill;
    logic [QW-1:0] issue_ext;

    // zero budget behaves as a budget of one
    assign refill    = (quantum_i == '0) ? QW'(1) : quantum_i;
    assign issue_ext = QW'(issue_i);
    assign exhaust_o = (issue_ext >= remain_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= refill;
        end else if (exhaust_o) begin
            remain_q <= refill;
        end else begin
            remain_q <= remain_q - issue_ext;
        end
    end

endmodule

// File: rtl/rriq_order_update.sv
module rriq_order_update
    import rriq_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    parameter int SW        = idx_width(DEF_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0][SW-1:0] order_i,
    input  logic [NUM_SLOTS-1:0]         exhaust_i,
    output logic [NUM_SLOTS-1:0][SW-1:0] order_next_o
);

    localparam int CW = $clog2(NUM_SLOTS + 1);
    localparam logic [SW-1:0] LAST_POS = SW'(NUM_SLOTS - 1);

    slot_fate_e          fate     [NUM_SLOTS];
    logic [CW-1:0]       stay_acc [NUM_SLOTS+1];
    logic [CW-1:0]       rot_acc  [NUM_SLOTS+1];
    logic [SW-1:0]       dest     [NUM_SLOTS];

    assign stay_acc[0] = '0;
    assign rot_acc[0]  = '0;

    for (genvar p = 0; p < NUM_SLOTS; p++) begin : g_pos
        assign fate[p] = fate_of(exhaust_i[order_i[p]]);
        assign stay_acc[p+1] = stay_acc[p] + CW'(fate[p] == FATE_STAY);
        assign rot_acc[p+1]  = rot_acc[p]  + CW'(fate[p] == FATE_ROTATE);
        // survivors pack to the top, rotated slots fill from the bottom up
        assign dest[p] = (fate[p] == FATE_ROTATE) ? (LAST_POS - SW'(rot_acc[p]))
                                                  : SW'(stay_acc[p]);
    end

    always_comb begin
        order_next_o = '0;
        for (int p = 0; p < NUM_SLOTS; p++) begin
            order_next_o[dest[p]] = order_i[p];
        end
    end

endmodule

// File: rtl/rriq_level_map.sv
module rriq_level_map
    import rriq_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    parameter int SW        = idx_width(DEF_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0][SW-1:0] order_i,
    output logic [NUM_SLOTS-1:0][SW-1:0] level_o
);

    always_comb begin
        level_o = '0;
        for (int p = 0; p < NUM_SLOTS; p++) begin
            level_o[order_i[p]] = SW'(NUM_SLOTS - 1 - p);
        end
    end

endmodule

// File: rtl/rriq_sched.sv
module rriq_sched
    import rriq_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    parameter int QW        = DEF_QW,
    parameter int MAX_ISSUE = DEF_MAX_ISSUE,
    parameter int IW        = $clog2(MAX_ISSUE + 1),
    parameter int SW        = idx_width(NUM_SLOTS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_SLOTS-1:0][QW-1:0] quantum_i,
    input  logic [NUM_SLOTS-1:0][IW-1:0] issue_cnt_i,
    output logic [NUM_SLOTS-1:0][SW-1:0] order_o,
    output logic [NUM_SLOTS-1:0][SW-1:0] level_o
);

    logic [NUM_SLOTS-1:0]         exhaust;
    logic [NUM_SLOTS-1:0][SW-1:0] order_q;
    logic [NUM_SLOTS-1:0][SW-1:0] order_next;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        rriq_slot_ctr #(
            .QW (QW),
            .IW (IW)
        ) u_ctr (
            .clk       (clk),
            .rst       (rst),
            .quantum_i (quantum_i[s]),
            .issue_i   (issue_cnt_i[s]),
            .exhaust_o (exhaust[s])
        );
    end

    rriq_order_update #(
        .NUM_SLOTS (NUM_SLOTS),
        .SW        (SW)
    ) u_update (
        .order_i      (order_q),
        .exhaust_i    (exhaust),
        .order_next_o (order_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NUM_SLOTS; p++) begin
                order_q[p] <= SW'(p);
            end
        end else begin
            order_q <= order_next;
        end
    end

    rriq_level_map #(
        .NUM_SLOTS (NUM_SLOTS),
        .SW        (SW)
    ) u_level (
        .order_i (order_q),
        .level_o (level_o)
    );

    assign order_o = order_q;

endmodule

// File: rtl/rriq_sched_chk.sv
module rriq_sched_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int QW        = 8,
    parameter int MAX_ISSUE = 2,
    parameter int IW        = 2,
    parameter int SW        = 2
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_SLOTS-1:0][IW-1:0] issue_cnt_i,
    input logic [NUM_SLOTS-1:0][SW-1:0] order_o,
    input logic [NUM_SLOTS-1:0][SW-1:0] level_o
);

    logic [NUM_SLOTS-1:0]         seen;
    logic [NUM_SLOTS-1:0][SW-1:0] ident;
    logic [NUM_SLOTS-1:0][IW-1:0] issue_q;

    always_comb begin
        seen  = '0;
        ident = '0;
        for (int p = 0; p < NUM_SLOTS; p++) begin
            seen[order_o[p]] = 1'b1;
            ident[p] = SW'(p);
        end
    end

    always_ff @(posedge clk) begin
        issue_q <= issue_cnt_i;
    end

    // R1
    reset_order_chk: assert property (@(posedge clk)
        rst |=> (order_o == ident));

    // R11
    perm_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(seen) == NUM_SLOTS);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_cnt_i == '0) |=> $stable(order_o));

    // R5
    tail_source_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(order_o[NUM_SLOTS-1]) |-> (issue_q[order_o[NUM_SLOTS-1]] != '0));

    for (genvar p = 0; p < NUM_SLOTS; p++) begin : g_lvl
        // R2
        level_match_chk: assert property (@(posedge clk) disable iff (rst)
            level_o[order_o[p]] == SW'(NUM_SLOTS - 1 - p));
    end

endmodule

bind rriq_sched rriq_sched_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .QW        (QW),
    .MAX_ISSUE (MAX_ISSUE),
    .IW        (IW),
    .SW        (SW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_cnt_i (issue_cnt_i),
    .order_o     (order_o),
    .level_o     (level_o)
);

// File: tb/tb_rriq_sched.sv
module tb_rriq_sched;

    localparam int N  = 4;
    localparam int QW = 8;
    localparam int IW = 2;
    localparam int SW = 2;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [N-1:0][QW-1:0] quantum_i = '0;
    logic [N-1:0][IW-1:0] issue_cnt_i = '0;
    logic [N-1:0][SW-1:0] order_o;
    logic [N-1:0][SW-1:0] level_o;

    always #2.5 clk = ~clk;

    rriq_sched dut (
        .clk         (clk),
        .rst         (rst),
        .quantum_i   (quantum_i),
        .issue_cnt_i (issue_cnt_i),
        .order_o     (order_o),
        .level_o     (level_o)
    );

    typedef struct {
        int    ord [N];
        string tag;
    } exp_t;

    exp_t sb[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   qv   [N];
    int   mcnt [N];
    int   mord [N];
    bit   done = 0;

    function automatic int eff_q(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic compare_out(input int ord [N], input string tag);
        for (int p = 0; p < N; p++) begin
            n_tests++;
            if (int'(order_o[p]) != ord[p]) begin
                n_fail++;
                $display("FAIL %s: position %0d holds slot %0d, expected %0d",
                         tag, p, order_o[p], ord[p]);
            end
            n_tests++;
            if (int'(level_o[ord[p]]) != N - 1 - p) begin
                n_fail++;
                $display("FAIL R2 (%s): level of slot %0d is %0d, expected %0d",
                         tag, ord[p], level_o[ord[p]], N - 1 - p);
            end
        end
    endtask

    // monitor: pops one expected list per clock edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                bit   hit [N];
                e = sb.pop_front();
                compare_out(e.ord, e.tag);
                // R11: every slot appears exactly once
                foreach (hit[i]) hit[i] = 0;
                for (int p = 0; p < N; p++) hit[order_o[p]] = 1;
                n_tests++;
                for (int i = 0; i < N; i++) begin
                    if (!hit[i]) begin
                        n_fail++;
                        $display("FAIL R11: slot %0d missing from list, expected present", i);
                        break;
                    end
                end
            end
        end
    end

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        issue_cnt_i = '0;
        for (int s = 0; s < N; s++) quantum_i[s] = QW'(qv[s]);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < N; s++) begin
            mcnt[s] = eff_q(qv[s]);
            mord[s] = s;
        end
        // R1: identity order right after reset
        compare_out(mord, tag);
    endtask

    // driver: applies one cycle of issue and pushes the expected list
    task automatic step(input int a, input int b, input int c, input int d, input string tag);
        int   iss [N];
        bit   ex  [N];
        int   nord[N];
        int   k;
        exp_t e;
        iss[0] = a; iss[1] = b; iss[2] = c; iss[3] = d;
        @(negedge clk);
        for (int s = 0; s < N; s++) begin
            quantum_i[s]   = QW'(qv[s]);
            issue_cnt_i[s] = IW'(iss[s]);
        end
        for (int s = 0; s < N; s++) begin
            ex[s] = (iss[s] >= mcnt[s]);
            mcnt[s] = ex[s] ? eff_q(qv[s]) : mcnt[s] - iss[s];
        end
        k = 0;
        for (int p = 0; p < N; p++) begin
            if (!ex[mord[p]]) begin
                nord[k] = mord[p];
                k++;
            end
        end
        for (int p = N - 1; p >= 0; p--) begin
            if (ex[mord[p]]) begin
                nord[k] = mord[p];
                k++;
            end
        end
        mord = nord;
        e.ord = nord;
        e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int lfsr;
        qv = '{3, 3, 3, 3};
        do_reset("R1 reset");

        repeat (3) step(0, 0, 0, 0, "R3 idle");

        // R4/R5: slot 0 uses three instructions, goes to the bottom
        repeat (3) step(1, 0, 0, 0, "R4 R5 single rotate");
        // R6: slot 2 issues 2 then 2 with only 1 left
        step(0, 0, 2, 0, "R4 partial");
        step(0, 0, 2, 0, "R6 excess discarded");
        step(0, 0, 1, 0, "R6 reload to full");

        // R7: new quantum for slot 1 does not alter its running count
        qv[1] = 5;
        step(0, 1, 0, 0, "R7 count kept");
        step(0, 1, 0, 0, "R7 count kept");
        step(0, 1, 0, 0, "R7 old budget ends");
        repeat (4) step(0, 1, 0, 0, "R7 new budget");
        step(0, 1, 0, 0, "R7 new budget ends");

        // R8: two non-adjacent slots exhaust together
        qv = '{3, 3, 3, 3};
        do_reset("R1 reset again");
        step(0, 1, 0, 0, "R8 setup");
        step(0, 2, 0, 0, "R8 setup");
        step(2, 0, 0, 2, "R8 align");
        step(1, 0, 0, 1, "R8 simultaneous");
        step(0, 0, 0, 0, "R3 idle after");

        // R9: small budget overtakes larger budget
        qv = '{6, 1, 3, 3};
        do_reset("R1 reset R9");
        step(1, 1, 0, 0, "R9 small exhausts");
        repeat (4) step(1, 0, 0, 0, "R9 large counting");
        step(1, 0, 0, 0, "R9 large exhausts behind");

        // R10: zero quantum acts as one
        qv = '{0, 2, 2, 2};
        do_reset("R1 reset R10");
        step(1, 0, 0, 0, "R10 zero quantum");
        step(1, 0, 0, 0, "R10 zero quantum again");
        step(0, 1, 0, 0, "R10 others intact");

        // R11: pseudo-random mix
        qv = '{2, 5, 1, 4};
        do_reset("R1 reset R11");
        lfsr = 32'h1ACE;
        for (int i = 0; i < 300; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            step(lfsr % 3, (lfsr >> 2) % 3, (lfsr >> 4) % 3, (lfsr >> 6) % 3, "R11 random");
            if (i == 150) qv = '{7, 1, 3, 0};
        end
        step(0, 0, 0, 0, "R3 final idle");
        repeat (3) @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule